// File: doc/BRIEF.md
# Block-Transfer Host Register Window

This block is the host-side register window of a block-transfer management interface. A byte-wide bus with separate read and write strobes and an address reaches three registers: a control/status register, a data port and an interrupt mask register. The host pushes a request message into a request buffer with data writes. It then signals the controller by writing the attention bit of the control register. The controller side sees a one-cycle request event and the request length, and reads the stored bytes through its own index port.

The controller answers by loading bytes into the response buffer and pulsing a response-ready strobe with the response length. The host then drains the response one byte per data read. The block raises a level interrupt toward the host on response-ready and on management-software attention, subject to an enable bit. The controller side can also set or clear the software attention flag, and can issue a cold reset that disables the interrupt. The block does not interpret message contents.

Top module: `bt_host_window`

## Requirements
- R1: The address is reduced modulo the region size (default 4). Offset 0 selects control, offset 1 selects data and offset 2 selects mask. Any other offset reads 0xFF, and writes to it change nothing.
- R2: A control read returns bit7 controller busy, bit6 host busy, bit4 software attention and bit3 controller-to-host attention. Every other bit reads 0, and all bits are 0 after reset.
- R3: In a control write, a 1 in bit0 zeroes the request length and a 1 in bit1 zeroes the response read position. A 1 in bit3 or in bit4 clears that attention flag without touching the interrupt pending bit. A 1 in bit6 toggles host busy.
- R4: A control write with bit2 set sets controller busy and drives `req_event` high for exactly the following cycle.
- R5: A data write stores the byte at index `req_len` only when `req_len` is below 64. It then always increments `req_len`, so an overrun stays visible.
- R6: When the read position is below the response length, a data read returns the byte at that position and advances the position. On reaching the length, both position and length return to 0. When they are equal, a data read returns 0xFF.
- R7: The mask register reads bit0 enable and bit1 pending. Writing enable from 0 to 1 while either attention flag is set raises pending. Writing enable from 1 to 0 clears pending.
- R8: A mask write with bit1 set clears pending.
- R9: A `rsp_ready` pulse clears controller busy, sets controller-to-host attention, loads the response length and zeroes the read position. It raises pending only when enable is set.
- R10: A software-attention request that differs from the current flag updates it. Setting the flag with `sms_irq` high raises pending if enable is set and controller-to-host attention is clear. Clearing the flag drops pending if controller-to-host attention is clear. A request equal to the current flag is ignored.
- R11: A `cold_rst` pulse clears both enable and pending.
- R12: `host_irq` is high exactly when pending is set and `irq_use_en` is high.
- R13: When a host access and controller events fall in the same cycle, the host access takes effect first. Response-ready follows, then the software-attention request, and the cold reset last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the cycle of `bus_rd` |
| host_irq | output | 1 | Level interrupt toward the host |
| irq_use_en | input | 1 | Global interrupt use enable |
| rsp_byte_we | input | 1 | Controller writes a response byte |
| rsp_byte_idx | input | 6 | Response byte index |
| rsp_byte_data | input | 8 | Response byte value |
| rsp_ready | input | 1 | Response complete strobe |
| rsp_len_in | input | 7 | Response length, 1 to 64 |
| sms_req | input | 1 | Software attention update strobe |
| sms_val | input | 1 | Requested software attention value |
| sms_irq | input | 1 | Interrupt requested with a set |
| cold_rst | input | 1 | Cold reset strobe for the interrupt state |
| req_event | output | 1 | One-cycle request-ready event |
| req_len | output | 7 | Request length counter |
| req_rd_idx | input | 6 | Controller request byte index |
| req_rd_data | output | 8 | Request byte at `req_rd_idx` |

## Verification
The collision that matters is a host register write landing in the same cycle as a controller response-ready strobe. The bench drives a control write that clears controller-to-host attention on the same edge as `rsp_ready`, and expects the flag to read back as set. It also drives a mask write that clears pending on the same edge as a response with enable set, and expects pending to survive. Both results show that the host access is applied before the controller event.

// File: rtl/bt_win_pkg.sv
`timescale 1ns/1ps
package bt_win_pkg;
    typedef enum logic [1:0] {
        ACC_CTL  = 2'd0,
        ACC_DATA = 2'd1,
        ACC_MASK = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    // Control register bit positions (host software decodes these)
    localparam int CB_CLR_WR  = 0;
    localparam int CB_CLR_RD  = 1;
    localparam int CB_H2C_ATN = 2;
    localparam int CB_C2H_ATN = 3;
    localparam int CB_SW_ATN  = 4;
    localparam int CB_HBUSY   = 6;
    localparam int CB_CBUSY   = 7;

    // Mask register bit positions
    localparam int MB_EN   = 0;
    localparam int MB_PEND = 1;
endpackage

// File: rtl/bt_win_decode.sv
`timescale 1ns/1ps
module bt_win_decode #(
    parameter int ADDR_W = 8,
    parameter int REGION = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output bt_win_pkg::acc_e  kind
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(REGION - 1);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr & OFF_MASK;
        case (off)
            ADDR_W'(0): kind = bt_win_pkg::ACC_CTL;
            ADDR_W'(1): kind = bt_win_pkg::ACC_DATA;
            ADDR_W'(2): kind = bt_win_pkg::ACC_MASK;
            default:    kind = bt_win_pkg::ACC_NONE;
        endcase
    end
endmodule

// File: rtl/bt_byte_store.sv
`timescale 1ns/1ps
module bt_byte_store #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/bt_host_window.sv
`timescale 1ns/1ps
module bt_host_window #(
    parameter int ADDR_W = 8,
    parameter int REGION = 4,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              host_irq,
    input  logic              irq_use_en,
    input  logic              rsp_byte_we,
    input  logic [IDX_W-1:0]  rsp_byte_idx,
    input  logic [7:0]        rsp_byte_data,
    input  logic              rsp_ready,
    input  logic [CNT_W-1:0]  rsp_len_in,
    input  logic              sms_req,
    input  logic              sms_val,
    input  logic              sms_irq,
    input  logic              cold_rst,
    output logic              req_event,
    output logic [CNT_W-1:0]  req_len,
    input  logic [IDX_W-1:0]  req_rd_idx,
    output logic [7:0]        req_rd_data
);
    import bt_win_pkg::*;

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] req_len;
        logic [CNT_W-1:0] rsp_len;
        logic [CNT_W-1:0] rd_pos;
        logic             en;
        logic             pend;
        logic             c2h;
        logic             sw;
        logic             hbusy;
        logic             cbusy;
        logic             evt;
    } win_state_t;

    win_state_t s_q, s_d;
    acc_e       acc_kind;
    logic       req_we;
    logic [7:0] rsp_rdata;

    bt_win_decode #(.ADDR_W(ADDR_W), .REGION(REGION)) u_dec (
        .addr (bus_addr),
        .kind (acc_kind)
    );

    bt_byte_store #(.DEPTH(DEPTH)) u_req_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (req_we),
        .widx  (s_q.req_len[IDX_W-1:0]),
        .wdata (bus_wdata),
        .ridx  (req_rd_idx),
        .rdata (req_rd_data)
    );

    bt_byte_store #(.DEPTH(DEPTH)) u_rsp_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rsp_byte_we),
        .widx  (rsp_byte_idx),
        .wdata (rsp_byte_data),
        .ridx  (s_q.rd_pos[IDX_W-1:0]),
        .rdata (rsp_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.evt   = 1'b0;
        req_we    = 1'b0;
        bus_rdata = 8'hFF;

        // Host access first
        case (acc_kind)
            ACC_CTL: begin
                if (bus_rd) begin
                    bus_rdata = {s_q.cbusy, s_q.hbusy, 1'b0, s_q.sw, s_q.c2h, 3'b000};
                end
                if (bus_wr) begin
                    if (bus_wdata[CB_CLR_WR])  s_d.req_len = '0;
                    if (bus_wdata[CB_CLR_RD])  s_d.rd_pos  = '0;
                    if (bus_wdata[CB_C2H_ATN]) s_d.c2h     = 1'b0;
                    if (bus_wdata[CB_SW_ATN])  s_d.sw      = 1'b0;
                    if (bus_wdata[CB_HBUSY])   s_d.hbusy   = ~s_q.hbusy;
                    if (bus_wdata[CB_H2C_ATN]) begin
                        s_d.cbusy = 1'b1;
                        s_d.evt   = 1'b1;
                    end
                end
            end
            ACC_DATA: begin
                if (bus_wr) begin
                    req_we      = (s_q.req_len < CAP);
                    s_d.req_len = s_q.req_len + ONE;
                end
                if (bus_rd && (s_q.rd_pos < s_q.rsp_len)) begin
                    bus_rdata  = rsp_rdata;
                    s_d.rd_pos = s_q.rd_pos + ONE;
                    if (s_d.rd_pos == s_q.rsp_len) begin
                        s_d.rd_pos  = '0;
                        s_d.rsp_len = '0;
                    end
                end
            end
            ACC_MASK: begin
                if (bus_rd) begin
                    bus_rdata = {6'b0, s_q.pend, s_q.en};
                end
                if (bus_wr) begin
                    if (bus_wdata[MB_EN] != s_q.en) begin
                        if (bus_wdata[MB_EN]) begin
                            if (s_q.c2h || s_q.sw) s_d.pend = 1'b1;
                            s_d.en = 1'b1;
                        end else begin
                            s_d.pend = 1'b0;
                            s_d.en   = 1'b0;
                        end
                    end
                    if (bus_wdata[MB_PEND]) s_d.pend = 1'b0;
                end
            end
            default: ;
        endcase

        // Controller events follow, in fixed order
        if (rsp_ready) begin
            s_d.cbusy   = 1'b0;
            s_d.c2h     = 1'b1;
            s_d.rsp_len = rsp_len_in;
            s_d.rd_pos  = '0;
            if (s_d.en) s_d.pend = 1'b1;
        end

        if (sms_req && (sms_val != s_d.sw)) begin
            s_d.sw = sms_val;
            if (sms_val) begin
                if (sms_irq && !s_d.c2h && s_d.en) s_d.pend = 1'b1;
            end else if (!s_d.c2h) begin
                s_d.pend = 1'b0;
            end
        end

        if (cold_rst) begin
            s_d.en   = 1'b0;
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign host_irq  = s_q.pend & irq_use_en;
    assign req_event = s_q.evt;
    assign req_len   = s_q.req_len;
endmodule

// File: rtl/bt_host_window_chk.sv
`timescale 1ns/1ps
module bt_host_window_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       kind,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic             rsp_ready,
    input logic             cold_rst,
    input logic             irq_use_en,
    input logic             host_irq,
    input logic             req_event,
    input logic [CNT_W-1:0] req_len,
    input logic [CNT_W-1:0] rd_pos,
    input logic [CNT_W-1:0] rsp_len,
    input logic             en,
    input logic             pend,
    input logic             c2h,
    input logic             cbusy
);
    logic ctl_wr, data_wr;
    assign ctl_wr  = bus_wr && (kind == 2'd0);
    assign data_wr = bus_wr && (kind == 2'd1);

    // R11
    cold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst |=> (!en && !pend));

    // R9
    rsp_sets_atn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> (c2h && !cbusy));

    // R4
    evt_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_event |-> $past(ctl_wr && bus_wdata[2]));

    // R4
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[2] && !rsp_ready) |=> cbusy);

    // R5
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (req_len == $past(req_len) + CNT_W'(1)));

    // R7
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> en);

    // R6
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pos <= rsp_len);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (irq_use_en && pend));
endmodule

bind bt_host_window bt_host_window_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (acc_kind),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .rsp_ready  (rsp_ready),
    .cold_rst   (cold_rst),
    .irq_use_en (irq_use_en),
    .host_irq   (host_irq),
    .req_event  (req_event),
    .req_len    (req_len),
    .rd_pos     (s_q.rd_pos),
    .rsp_len    (s_q.rsp_len),
    .en         (s_q.en),
    .pend       (s_q.pend),
    .c2h        (s_q.c2h),
    .cbusy      (s_q.cbusy)
);

// File: tb/bt_host_window_test.sv
`timescale 1ns/1ps
module bt_host_window_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       host_irq;
    logic       irq_use_en = 1'b1;
    logic       rsp_byte_we = 1'b0;
    logic [5:0] rsp_byte_idx = '0;
    logic [7:0] rsp_byte_data = '0;
    logic       rsp_ready = 1'b0;
    logic [6:0] rsp_len_in = '0;
    logic       sms_req = 1'b0;
    logic       sms_val = 1'b0;
    logic       sms_irq = 1'b0;
    logic       cold_rst = 1'b0;
    logic       req_event;
    logic [6:0] req_len;
    logic [5:0] req_rd_idx = '0;
    logic [7:0] req_rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] req_mdl [64];
    logic [7:0] rsp_mdl [64];

    always #4 clk = ~clk;

    bt_host_window uut (.*);

    function automatic logic [7:0] ctl_byte(input logic cb, hb, sw, c2h);
        return {cb, hb, 1'b0, sw, c2h, 3'b000};
    endfunction

    function automatic logic [7:0] mask_byte(input logic pend, en);
        return {6'b0, pend, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(req, {24'b0, v}, {24'b0, exp});
    endtask

    task automatic ctl_evt(input logic rr, input logic [6:0] ln,
                           input logic sq, input logic sv, input logic si, input logic cr);
        @(negedge clk);
        rsp_ready = rr; rsp_len_in = ln; sms_req = sq; sms_val = sv; sms_irq = si; cold_rst = cr;
        @(negedge clk);
        rsp_ready = 1'b0; sms_req = 1'b0; cold_rst = 1'b0;
    endtask

    task automatic load_rsp(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rsp_byte_we = 1'b1; rsp_byte_idx = 6'(i);
            rsp_byte_data = 8'($urandom); rsp_mdl[i] = rsp_byte_data;
        end
        @(negedge clk); rsp_byte_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd_chk(8'd0, ctl_byte(0, 0, 0, 0), "R2 reset ctl");
        rd_chk(8'd2, mask_byte(0, 0), "R7 reset mask");
        chk("R12 reset irq", {31'b0, host_irq}, 32'd0);
        chk("R5 reset len", {25'b0, req_len}, 32'd0);

        // R1 decode and aliasing
        rd_chk(8'd3, 8'hFF, "R1 offset 3");
        rd_chk(8'd7, 8'hFF, "R1 offset 7 alias");
        wr(8'd3, 8'hFF);
        rd_chk(8'd0, ctl_byte(0, 0, 0, 0), "R1 write ignored");
        wr(8'd6, 8'h01);
        rd_chk(8'd2, mask_byte(0, 1), "R1 mask alias");
        wr(8'd2, 8'h00);

        // R3 host busy toggle
        wr(8'd0, 8'h40);
        rd_chk(8'd0, ctl_byte(0, 1, 0, 0), "R3 hbusy on");
        wr(8'd0, 8'h40);
        rd_chk(8'd0, ctl_byte(0, 0, 0, 0), "R3 hbusy off");

        // R5 random requests, some overrunning
        for (int t = 0; t < 4; t++) begin
            int n;
            n = (t == 3) ? 70 : 1 + int'($urandom % 64);
            wr(8'd0, 8'h01);
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                if (i < 64) req_mdl[i] = b;
                wr(8'd1, b);
            end
            chk("R5 length", {25'b0, req_len}, 32'(n));
            for (int i = 0; i < ((n < 64) ? n : 64); i++) begin
                @(negedge clk); req_rd_idx = 6'(i);
                #1 chk("R5 stored byte", {24'b0, req_rd_data}, {24'b0, req_mdl[i]});
            end
        end

        // R4 request event
        @(negedge clk); bus_addr = 8'd0; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R4 event pulse", {31'b0, req_event}, 32'd1);
        @(negedge clk);
        chk("R4 event ends", {31'b0, req_event}, 32'd0);
        rd_chk(8'd0, ctl_byte(1, 0, 0, 0), "R4 cbusy");
        wr(8'd0, 8'h01);
        chk("R3 clear write ptr", {25'b0, req_len}, 32'd0);

        // R6 / R9 random responses with enable off
        for (int t = 0; t < 3; t++) begin
            int l;
            l = 1 + int'($urandom % 64);
            load_rsp(l);
            ctl_evt(1'b1, 7'(l), 1'b0, 1'b0, 1'b0, 1'b0);
            rd_chk(8'd0, ctl_byte(0, 0, 0, 1), "R9 ctl after ready");
            rd_chk(8'd2, mask_byte(0, 0), "R9 no pend when disabled");
            for (int i = 0; i < l; i++) rd_chk(8'd1, rsp_mdl[i], "R6 response byte");
            rd_chk(8'd1, 8'hFF, "R6 empty read");
        end

        // R7 enable with attention pending, R12 gating, R8 clear
        wr(8'd2, 8'h01);
        rd_chk(8'd2, mask_byte(1, 1), "R7 enable raises pend");
        chk("R12 irq high", {31'b0, host_irq}, 32'd1);
        @(negedge clk); irq_use_en = 1'b0;
        #1 chk("R12 irq gated", {31'b0, host_irq}, 32'd0);
        irq_use_en = 1'b1;
        wr(8'd2, 8'h03);
        rd_chk(8'd2, mask_byte(0, 1), "R8 pend cleared");
        chk("R8 irq low", {31'b0, host_irq}, 32'd0);

        // R9 pend on ready, R3 clear read pointer, attention W1C
        load_rsp(3);
        ctl_evt(1'b1, 7'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_chk(8'd2, mask_byte(1, 1), "R9 pend raised");
        rd_chk(8'd1, rsp_mdl[0], "R6 first byte");
        wr(8'd0, 8'h02);
        rd_chk(8'd1, rsp_mdl[0], "R3 clear read ptr");
        wr(8'd0, 8'h08);
        rd_chk(8'd0, ctl_byte(0, 0, 0, 0), "R3 c2h cleared");
        rd_chk(8'd2, mask_byte(1, 1), "R3 pend untouched");
        wr(8'd2, 8'h00);
        rd_chk(8'd2, mask_byte(0, 0), "R7 disable clears pend");

        // R10 software attention
        wr(8'd2, 8'h01);
        ctl_evt(1'b0, 7'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        rd_chk(8'd0, ctl_byte(0, 0, 1, 0), "R10 sw set");
        rd_chk(8'd2, mask_byte(1, 1), "R10 sw pend");
        wr(8'd2, 8'h03);
        ctl_evt(1'b0, 7'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        rd_chk(8'd2, mask_byte(0, 1), "R10 same value ignored");
        wr(8'd2, 8'h00);
        wr(8'd2, 8'h01);
        rd_chk(8'd2, mask_byte(1, 1), "R7 enable with sw atn");
        ctl_evt(1'b0, 7'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        rd_chk(8'd2, mask_byte(0, 1), "R10 sw clear drops pend");
        ctl_evt(1'b0, 7'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        rd_chk(8'd2, mask_byte(0, 1), "R10 set without irq");
        wr(8'd0, 8'h10);
        rd_chk(8'd0, ctl_byte(0, 0, 0, 0), "R3 sw W1C");

        // R11 cold reset
        ctl_evt(1'b0, 7'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        rd_chk(8'd2, mask_byte(1, 1), "R11 pre pend");
        ctl_evt(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        rd_chk(8'd2, mask_byte(0, 0), "R11 cold clears");
        chk("R11 irq low", {31'b0, host_irq}, 32'd0);
        wr(8'd0, 8'h10);

        // R13 same-cycle host write and response ready
        load_rsp(2);
        @(negedge clk);
        bus_addr = 8'd0; bus_wdata = 8'h08; bus_wr = 1'b1; rsp_ready = 1'b1; rsp_len_in = 7'd2;
        @(negedge clk); bus_wr = 1'b0; rsp_ready = 1'b0;
        rd_chk(8'd0, ctl_byte(0, 0, 0, 1), "R13 c2h survives W1C");
        wr(8'd2, 8'h01);
        @(negedge clk);
        bus_addr = 8'd2; bus_wdata = 8'h03; bus_wr = 1'b1; rsp_ready = 1'b1; rsp_len_in = 7'd2;
        @(negedge clk); bus_wr = 1'b0; rsp_ready = 1'b0;
        rd_chk(8'd2, mask_byte(1, 1), "R13 pend survives clear");
        rd(8'd1, v);
        chk("R13 response intact", {24'b0, v}, {24'b0, rsp_mdl[0]});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule